// File: doc/BRIEF.md
# Watchdog Timer with Interval Selection

This block is a watchdog timer driven by one 32-bit control register on a simple register bus. After software enables it and writes the restart bit, it counts prescaled clock ticks. When the selected interval has passed, it sets a sticky interrupt flag as an early warning. The interrupt output follows that flag while interrupts are enabled. If software still does not restart the count, the block waits a further fixed number of prescaled ticks. It then drives a system reset pulse of fixed length, provided the reset path is enabled, and records a sticky reset flag.

The timeout has two independent selection fields. A divider select stretches the tick period by a factor of 8 per step. An interval select lengthens the count by a factor of 4 per step. The two fields together cover a wide range of timeouts. The base tick period, the interval exponent, the extra delay before reset and the pulse length are parameters, so short settings can be used during verification.

Software services the watchdog with a read-modify-write. It sets the restart bit and keeps every other field as it was. Writing all zeros stops the watchdog.

Top module: `wdog_timer`

## Requirements
- R1: The control register sits at byte address 0x1C. Its read value is: bits 11:10 divider select, bit 7 enable, bit 6 interrupt enable, bits 5:4 interval select, bit 3 interrupt flag, bit 2 reset flag, bit 1 reset enable, bit 0 restart. All other bits read 0. Read data appears registered one cycle after the read strobe. Writes to any other address are ignored.
- R2: After reset the register reads 0 and both the interrupt and reset outputs are low.
- R3: The restart bit always reads 0. Writing 1 to it clears the prescaler and the tick count and leaves all other fields as written.
- R4: With enable set, the interrupt flag sets exactly BASE_CYCLES * 8^div * 4^isel * 2^INT_EXP clock cycles after the register write that restarted the count.
- R5: The interrupt output equals the interrupt flag ANDed with interrupt enable. With interrupt enable clear, the flag still sets and the output stays low.
- R6: Writing 1 to bit 3 clears the interrupt flag, and writing 1 to bit 2 clears the reset flag. Writing 0 to either bit leaves that flag unchanged.
- R7: With reset enable set, EXTRA_TICKS prescaled ticks after the interrupt point, the reset output goes high for exactly RST_CYCLES cycles and the reset flag sets.
- R8: With reset enable clear, the reset output never asserts and the reset flag never sets.
- R9: While enable is clear, the prescaler and the count hold their values and neither flag can set. When enable is set again without a restart, counting resumes from the held count.
- R10: Writing all zeros stops the watchdog. The register then reads 0 and no interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| wdt_irq | output | 1 | Early-warning interrupt |
| wdt_rst_out | output | 1 | System reset pulse |

## Verification
Every one of the sixteen divider and interval combinations is started from a restart and sampled one cycle before and exactly at the expected expiry. This separates an error in the factor-of-8 divider from one in the factor-of-4 interval, and catches any off-by-one in the tick path. Directed patterns cover the following:
- a restart in mid-count, which must push expiry later;
- a pause through the enable bit, which must hold the count;
- a run with reset enabled, which must give a pulse of exact position and length;
- a run with reset disabled, which must give no pulse;
- flag clearing, where writing 0 and writing 1 to a flag bit must behave differently;
- a write to a non-matching address.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W    = 32;
  localparam int B_RESTART = 0;
  localparam int B_RST_EN  = 1;
  localparam int B_RST_FLG = 2;
  localparam int B_IRQ_FLG = 3;
  localparam int B_ISEL_LO = 4;
  localparam int B_IRQ_EN  = 6;
  localparam int B_ENABLE  = 7;
  localparam int B_DIV_LO  = 10;
  localparam int DIV_STEP_LOG2  = 3;  // x8 per divider step
  localparam int ISEL_STEP_LOG2 = 2;  // x4 per interval step
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int BASE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       ptick
);
  import wdog_pkg::*;
  localparam int DIV_W = 3 * DIV_STEP_LOG2;
  localparam int BW    = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1;

  logic             base_tick;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_lim;

  generate
    if (BASE_CYCLES == 1) begin : g_direct
      assign base_tick = enable;
    end else begin : g_count
      logic [BW-1:0] base_cnt;
      assign base_tick = enable && (base_cnt == BW'(BASE_CYCLES - 1));
      always_ff @(posedge clk) begin
        if (rst || restart)  base_cnt <= '0;
        else if (base_tick)  base_cnt <= '0;
        else if (enable)     base_cnt <= base_cnt + 1'b1;
      end
    end
  endgenerate

  always_comb div_lim = DIV_W'((1 << (DIV_STEP_LOG2 * int'(div_sel))) - 1);

  assign ptick = base_tick && (div_cnt >= div_lim);

  always_ff @(posedge clk) begin
    if (rst || restart)  div_cnt <= '0;
    else if (ptick)      div_cnt <= '0;
    else if (base_tick)  div_cnt <= div_cnt + 1'b1;
  end

  a_r9_halt_hold: assert property (@(posedge clk) disable iff (rst)
    (!enable && !restart) |=> $stable(div_cnt));
endmodule

// File: rtl/wdog_interval_counter.sv
module wdog_interval_counter #(
  parameter int INT_EXP     = 4,
  parameter int EXTRA_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ptick,
  input  logic       restart,
  input  logic [1:0] isel,
  output logic       irq_evt,
  output logic       rst_evt
);
  import wdog_pkg::*;
  localparam int MAX_CNT = (1 << (INT_EXP + 3 * ISEL_STEP_LOG2)) + EXTRA_TICKS;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] irq_pt;
  logic [CNT_W-1:0] end_pt;

  always_comb begin
    irq_pt = CNT_W'(1) << (INT_EXP + ISEL_STEP_LOG2 * int'(isel));
    end_pt = irq_pt + CNT_W'(EXTRA_TICKS);
  end

  assign irq_evt = ptick && (cnt_q == irq_pt - 1'b1);
  assign rst_evt = ptick && (cnt_q == end_pt - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart)                 cnt_q <= '0;
    else if (ptick && cnt_q != end_pt)  cnt_q <= cnt_q + 1'b1;
  end

  a_r4_single_event: assert property (@(posedge clk) disable iff (rst)
    !(irq_evt && rst_evt));
endmodule

// File: rtl/wdog_reset_pulse.sv
module wdog_reset_pulse #(
  parameter int RST_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  localparam int PW = $clog2(RST_CYCLES + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      left_q <= '0;
    end else if (fire) begin
      pulse  <= 1'b1;
      left_q <= PW'(RST_CYCLES - 1);
    end else if (pulse) begin
      if (left_q == '0) pulse <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  a_r7_pulse_held: assert property (@(posedge clk) disable iff (rst)
    (pulse && left_q != '0) |=> pulse);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int ADDR_W      = 8,
  parameter int CTRL_OFS    = 'h1C,
  parameter int BASE_CYCLES = 16,
  parameter int INT_EXP     = 4,
  parameter int EXTRA_TICKS = 1024,
  parameter int RST_CYCLES  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst_out
);
  import wdog_pkg::*;

  logic       en_q, ie_q, re_q, irq_flag_q, rst_flag_q;
  logic [1:0] div_q, isel_q;
  logic       hit_wr, hit_rd, restart;
  logic       ptick, irq_evt, rst_evt, rst_fire;
  logic [DATA_W-1:0] view;

  assign hit_wr  = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
  assign hit_rd  = reg_rd && (reg_addr == ADDR_W'(CTRL_OFS));
  assign restart = hit_wr && reg_wdata[B_RESTART];

  wdog_prescaler #(.BASE_CYCLES(BASE_CYCLES)) u_pre (
    .clk(clk), .rst(rst), .enable(en_q), .restart(restart),
    .div_sel(div_q), .ptick(ptick));

  wdog_interval_counter #(.INT_EXP(INT_EXP), .EXTRA_TICKS(EXTRA_TICKS)) u_cnt (
    .clk(clk), .rst(rst), .ptick(ptick), .restart(restart),
    .isel(isel_q), .irq_evt(irq_evt), .rst_evt(rst_evt));

  assign rst_fire = rst_evt && re_q;

  wdog_reset_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .fire(rst_fire), .pulse(wdt_rst_out));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; ie_q <= 1'b0; re_q <= 1'b0;
      div_q <= '0;  isel_q <= '0;
    end else if (hit_wr) begin
      en_q   <= reg_wdata[B_ENABLE];
      ie_q   <= reg_wdata[B_IRQ_EN];
      re_q   <= reg_wdata[B_RST_EN];
      div_q  <= reg_wdata[B_DIV_LO +: 2];
      isel_q <= reg_wdata[B_ISEL_LO +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag_q <= 1'b0;
      rst_flag_q <= 1'b0;
    end else begin
      if (irq_evt)                             irq_flag_q <= 1'b1;
      else if (hit_wr && reg_wdata[B_IRQ_FLG]) irq_flag_q <= 1'b0;
      if (rst_fire)                            rst_flag_q <= 1'b1;
      else if (hit_wr && reg_wdata[B_RST_FLG]) rst_flag_q <= 1'b0;
    end
  end

  always_comb begin
    view = '0;
    view[B_DIV_LO +: 2]  = div_q;
    view[B_ENABLE]       = en_q;
    view[B_IRQ_EN]       = ie_q;
    view[B_ISEL_LO +: 2] = isel_q;
    view[B_IRQ_FLG]      = irq_flag_q;
    view[B_RST_FLG]      = rst_flag_q;
    view[B_RST_EN]       = re_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (hit_rd) reg_rdata <= view;
    else             reg_rdata <= '0;
  end

  assign wdt_irq = irq_flag_q && ie_q;

  a_r3_restart_reads_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rdata[B_RESTART]);
  a_r9_no_flag_when_off: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !$rose(irq_flag_q));
  a_r8_flag_needs_rst_en: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_flag_q) |-> $past(re_q));
  a_r7_pulse_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_out) |-> $past(en_q));
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int EXTRA = 8;
  localparam int RSTC  = 4;
  localparam logic [7:0] CTRL = 8'h1C;

  // [31:30] div, [29:28] isel, [23:0] cycles to interrupt
  localparam logic [31:0] VEC [16] = '{
    32'h0000_0001, 32'h1000_0004, 32'h2000_0010, 32'h3000_0040,
    32'h4000_0008, 32'h5000_0020, 32'h6000_0080, 32'h7000_0200,
    32'h8000_0040, 32'h9000_0100, 32'hA000_0400, 32'hB000_1000,
    32'hC000_0200, 32'hD000_0800, 32'hE000_2000, 32'hF000_8000};

  logic clk = 0, rst = 1, reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic wdt_irq, wdt_rst_out;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.BASE_CYCLES(1), .INT_EXP(0), .EXTRA_TICKS(EXTRA), .RST_CYCLES(RSTC)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_irq(wdt_irq),
    .wdt_rst_out(wdt_rst_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = CTRL;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R2 reset state
    chk("R2 irq", wdt_irq, 0);
    chk("R2 rst", wdt_rst_out, 0);
    rd(rv); chk("R2 reg", rv, 0);

    // R4 all divider/interval combinations
    foreach (VEC[k]) begin
      wr(CTRL, 32'hC1 | (32'(VEC[k][31:30]) << 10) | (32'(VEC[k][29:28]) << 4));
      repeat (int'(VEC[k][23:0]) - 1) @(negedge clk);
      chk("R4 before expiry", wdt_irq, 0);
      @(negedge clk);
      chk("R4 at expiry", wdt_irq, 1);
      wr(CTRL, 32'h08);
    end

    // R1 R3 readback, restart reads 0
    wr(CTRL, 32'hCF3);
    rd(rv); chk("R3 R1 readback", rv, 32'hCF2);
    wr(CTRL, 32'h0);
    rd(rv); chk("R10 stop reads zero", rv, 0);

    // R1 write to another address ignored
    wr(8'h18, 32'hC1);
    rd(rv); chk("R1 other address", rv, 0);

    // R3 restart mid-count pushes expiry later (isel=1: 4 cycles)
    wr(CTRL, 32'hD1);
    wr(CTRL, 32'hD1);
    repeat (3) @(negedge clk);
    chk("R3 restart delays", wdt_irq, 0);
    @(negedge clk);
    chk("R3 restart expiry", wdt_irq, 1);
    wr(CTRL, 32'h08);

    // R9 disable holds count, resumes
    wr(CTRL, 32'hD1);
    wr(CTRL, 32'h50);
    repeat (20) @(negedge clk);
    chk("R9 halted no irq", wdt_irq, 0);
    wr(CTRL, 32'hD0);
    @(negedge clk);
    chk("R9 resume not yet", wdt_irq, 0);
    @(negedge clk);
    chk("R9 resume expiry", wdt_irq, 1);
    wr(CTRL, 32'h08);

    // R7 reset pulse
    wr(CTRL, 32'h83);
    repeat (EXTRA) @(negedge clk);
    chk("R7 before pulse", wdt_rst_out, 0);
    @(negedge clk);
    chk("R7 pulse start", wdt_rst_out, 1);
    repeat (RSTC - 1) @(negedge clk);
    chk("R7 pulse last", wdt_rst_out, 1);
    @(negedge clk);
    chk("R7 pulse end", wdt_rst_out, 0);
    chk("R5 irq masked", wdt_irq, 0);
    rd(rv); chk("R7 R5 flags", rv, 32'h8E);
    wr(CTRL, 32'h0C);
    rd(rv); chk("R6 flags cleared", rv, 0);

    // R8 no reset without reset enable
    wr(CTRL, 32'h81);
    begin
      logic seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (wdt_rst_out) seen = 1;
      end
      chk("R8 no pulse", seen, 0);
    end
    rd(rv); chk("R8 flags", rv, 32'h88);
    wr(CTRL, 32'h80);
    rd(rv); chk("R6 write 0 keeps flag", rv, 32'h88);
    wr(CTRL, 32'h08);
    rd(rv); chk("R6 write 1 clears", rv, 0);

    // R10 stop before expiry
    wr(CTRL, 32'hF1);
    wr(CTRL, 32'h0);
    repeat (100) @(negedge clk);
    chk("R10 no irq after stop", wdt_irq, 0);
    rd(rv); chk("R10 reads zero", rv, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule